// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block produces the active-low system reset from digitized supply status, an active-low manual reset request and a software watchdog. A comparator outside the block reports whether the output rail is above the reset threshold. While that flag is low, reset is held. Once every cause has cleared, a release delay must run out before reset is lifted.

A free-running tick enable paces the release delay and the watchdog timeout. Both lengths are parameters counted in ticks, so a fast simulation can use short values. Software keeps the system alive by toggling the watchdog input, and a change in either direction restarts the timer.

A separate flag reports that the watchdog input is left unconnected. While that flag is set, an internal source produces the transitions that keep the watchdog satisfied. That source stays low for seven eighths of the timeout period and then goes high for one tick.

Top module: `supply_wdog_sup`

## Requirements
- R1: `rst_no` is 0 while `rst_ni` is low, and stays 0 for as long as `rail_ok_i` is 0.
- R2: Once `rail_ok_i`, `mr_ni` and the watchdog are all clear, `rst_no` rises only after DELAY_TICKS ticks of the release delay. The two-flop input synchronizer adds two clocks to this.
- R3: When `rail_ok_i` falls, `rst_no` goes to 0 in the same cycle, without waiting for any register or timer.
- R4: A 0 on `mr_ni` asserts reset within three clocks. After `mr_ni` returns to 1, release follows the delay of R2.
- R5: A rising edge and a falling edge on `wdi_i` each restart the watchdog. Edges spaced fewer than WDT_TICKS ticks apart keep reset released, even when two consecutive edges of the same direction are further apart than WDT_TICKS.
- R6: When WDT_TICKS ticks pass after release or after the last watchdog restart with no edge, reset is asserted. It is then held for exactly DELAY_TICKS ticks.
- R7: While `wdi_float_i` is 1, `wdi_i` is ignored. An internal source restarts the watchdog instead: it is low for (WDT_TICKS*7)/8 ticks of every WDT_TICKS-tick period and high for one tick. A change of `wdi_float_i` also restarts the watchdog. No watchdog reset occurs while the flag is held.
- R8: The watchdog count stays at zero while reset is asserted and starts at release. A timeout therefore comes WDT_TICKS ticks after release, regardless of how long reset was held.
- R9: A reset cause that appears while the release delay runs restarts the delay from zero.
- R10: The release delay and the watchdog advance only in cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| rail_ok_i | input | 1 | Output rail above the reset threshold |
| mr_ni | input | 1 | Manual reset request, active low |
| wdi_i | input | 1 | Watchdog input from software |
| wdi_float_i | input | 1 | Watchdog input is unconnected |
| rst_no | output | 1 | System reset, active low |

## Verification
With a tick in every cycle, a change on `mr_ni` or a rise of `rail_ok_i` reaches `rst_no` after the two synchronizer clocks plus DELAY_TICKS clocks. A watchdog edge clears the timer three clocks after it is driven. After release, a timeout asserts reset WDT_TICKS clocks later. A fall of `rail_ok_i` shows on the output in the same cycle.

The bench drives its inputs on the falling clock edge and samples there too. Each check is placed either where the computed latency says the output is still unchanged or where it must already have changed. Where an exact count matters, the bench counts clocks at the output: the timeout window, the hold length after a timeout, and the point where ticks resume.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic rail_ok;
    logic mr_n;
    logic wdi;
    logic wdi_float;
  } sup_in_t;

  localparam int unsigned SUP_IN_W = $bits(sup_in_t);
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sup_wdi_src.sv
module sup_wdi_src #(
  parameter int unsigned WDT_TICKS = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic float_i,
  input  logic wdi_i,
  output logic kick_o
);
  localparam int unsigned PH_W     = (WDT_TICKS > 2) ? $clog2(WDT_TICKS) : 1;
  localparam int unsigned PULSE_AT = (WDT_TICKS * 7) / 8;
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(WDT_TICKS - 1);
  localparam logic [PH_W-1:0] PH_PULSE = PH_W'(PULSE_AT);

  logic [PH_W-1:0] ph_q;
  logic            drive, eff, eff_q, flt_q;

  // phase restarts whenever the input is driven, so the first pulse is a known distance away
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (!float_i)    ph_q <= '0;
    else if (tick_i)      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  assign drive = (ph_q == PH_PULSE);
  assign eff   = float_i ? drive : wdi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      eff_q <= eff;
      flt_q <= float_i;
    end
  end

  assign kick_o = (eff ^ eff_q) | (float_i ^ flt_q);
endmodule

// File: rtl/sup_wdt.sv
module sup_wdt #(
  parameter int unsigned WDT_TICKS = 800,
  localparam int unsigned CW = (WDT_TICKS > 2) ? $clog2(WDT_TICKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          kick_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] LAST = CW'(WDT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || kick_i)       cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign expire_o = run_i && tick_i && !kick_i && (cnt_q == LAST);
endmodule

// File: rtl/sup_rel_dly.sv
module sup_rel_dly #(
  parameter int unsigned DELAY_TICKS = 100,
  localparam int unsigned CW = (DELAY_TICKS > 2) ? $clog2(DELAY_TICKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cause_i,
  output logic [CW-1:0] cnt_o,
  output logic          rel_o
);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (cause_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q && tick_i) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign rel_o = rel_q;
endmodule

// File: rtl/supply_wdog_sup.sv
module supply_wdog_sup #(
  parameter int unsigned DELAY_TICKS = 100,
  parameter int unsigned WDT_TICKS   = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rail_ok_i,
  input  logic mr_ni,
  input  logic wdi_i,
  input  logic wdi_float_i,
  output logic rst_no
);
  import sup_pkg::*;

  localparam int unsigned DCW = (DELAY_TICKS > 2) ? $clog2(DELAY_TICKS) : 1;
  localparam int unsigned WCW = (WDT_TICKS > 2) ? $clog2(WDT_TICKS) : 1;

  sup_in_t            in_raw, in_s;
  logic [SUP_IN_W-1:0] in_q;
  logic               kick, wdt_exp, cause, rel_q;
  logic [DCW-1:0]     dly_cnt;
  logic [WCW-1:0]     wd_cnt;

  assign in_raw = '{rail_ok: rail_ok_i, mr_n: mr_ni, wdi: wdi_i, wdi_float: wdi_float_i};

  sup_sync #(.WIDTH(SUP_IN_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (in_raw),
    .q_o    (in_q)
  );
  assign in_s = sup_in_t'(in_q);

  sup_wdi_src #(.WDT_TICKS(WDT_TICKS)) u_wdi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .float_i (in_s.wdi_float),
    .wdi_i   (in_s.wdi),
    .kick_o  (kick)
  );

  sup_wdt #(.WDT_TICKS(WDT_TICKS)) u_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (rel_q),
    .kick_i   (kick),
    .cnt_o    (wd_cnt),
    .expire_o (wdt_exp)
  );

  assign cause = !in_s.rail_ok || !in_s.mr_n || wdt_exp;

  sup_rel_dly #(.DELAY_TICKS(DELAY_TICKS)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cause_i (cause),
    .cnt_o   (dly_cnt),
    .rel_o   (rel_q)
  );

  // raw rail flag gates the output so a drop bypasses the synchronizer
  assign rst_no = rel_q && rail_ok_i;
endmodule

// File: rtl/supply_wdog_sup_chk.sv
module supply_wdog_sup_chk #(
  parameter int unsigned DELAY_TICKS = 100,
  parameter int unsigned WDT_TICKS   = 800,
  localparam int unsigned DCW = (DELAY_TICKS > 2) ? $clog2(DELAY_TICKS) : 1,
  localparam int unsigned WCW = (WDT_TICKS > 2) ? $clog2(WDT_TICKS) : 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick_i,
  input logic           rail_ok_i,
  input logic           mr_s,
  input logic           cause,
  input logic           wdt_exp,
  input logic           rel_q,
  input logic [DCW-1:0] dly_cnt,
  input logic [WCW-1:0] wd_cnt,
  input logic           rst_no
);
  int unsigned lo_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 lo_ticks <= 0;
    else if (rel_q)                              lo_ticks <= 0;
    else if (tick_i && lo_ticks < DELAY_TICKS)   lo_ticks <= lo_ticks + 1;
  end

  // R3
  rail_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rail_ok_i |-> !rst_no);

  // R2
  release_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> (lo_ticks >= DELAY_TICKS));

  // R4
  manual_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_s |=> !rst_no);

  // R6
  wdt_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_exp |=> !rst_no);

  // R8
  wdt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_q |=> (wd_cnt == '0));

  // R9
  delay_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause |=> (dly_cnt == '0) && !rel_q);

  // R10
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cause) |=> $stable(dly_cnt) && $stable(rel_q));
endmodule

bind supply_wdog_sup supply_wdog_sup_chk #(
  .DELAY_TICKS (DELAY_TICKS),
  .WDT_TICKS   (WDT_TICKS)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rail_ok_i (rail_ok_i),
  .mr_s      (in_s.mr_n),
  .cause     (cause),
  .wdt_exp   (wdt_exp),
  .rel_q     (rel_q),
  .dly_cnt   (dly_cnt),
  .wd_cnt    (wd_cnt),
  .rst_no    (rst_no)
);

// File: tb/supply_wdog_sup_tb_top.sv
module supply_wdog_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int W = 32;
  localparam int KICK_GAP = 20;

  logic clk = 1'b0;
  logic rst_ni, tick_i, rail_ok_i, mr_ni, wdi_i, wdi_float_i;
  logic rst_no;
  logic kick_en = 1'b0;
  logic done = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_wdog_sup #(.DELAY_TICKS(D), .WDT_TICKS(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .rail_ok_i   (rail_ok_i),
    .mr_ni       (mr_ni),
    .wdi_i       (wdi_i),
    .wdi_float_i (wdi_float_i),
    .rst_no      (rst_no)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // background software kick, one toggle every KICK_GAP clocks
  initial begin
    int kc = 0;
    forever begin
      @(negedge clk);
      if (kick_en) begin
        kc++;
        if (kc >= KICK_GAP) begin
          wdi_i = ~wdi_i;
          kc = 0;
        end
      end else kc = 0;
    end
  end

  task automatic t_power_on;
    rst_ni = 1'b0; tick_i = 1'b1; rail_ok_i = 1'b1; mr_ni = 1'b1;
    wdi_i = 1'b0; wdi_float_i = 1'b0;
    cyc(3);
    check("R1 reset held in power-on reset", rst_no, 0);
    rst_ni = 1'b1;
    cyc(D);
    check("R2 still low before delay", rst_no, 0);
    cyc(4);
    check("R2 released after delay", rst_no, 1);
    kick_en = 1'b1;
  endtask

  task automatic t_rail_drop;
    rail_ok_i = 1'b0;
    #1;
    check("R3 immediate assert on rail drop", rst_no, 0);
    cyc(20);
    check("R1 held while rail low", rst_no, 0);
    rail_ok_i = 1'b1;
    cyc(D);
    check("R2 low before delay after rail return", rst_no, 0);
    cyc(4);
    check("R2 released after rail return", rst_no, 1);
  endtask

  task automatic t_manual;
    mr_ni = 1'b0;
    cyc(4);
    check("R4 manual reset asserts", rst_no, 0);
    cyc(4);
    mr_ni = 1'b1;
    cyc(D);
    check("R4 low during delay after manual reset", rst_no, 0);
    cyc(4);
    check("R4 released after delay", rst_no, 1);
  endtask

  task automatic t_restart;
    mr_ni = 1'b0;
    cyc(4);
    mr_ni = 1'b1;
    cyc(4);
    mr_ni = 1'b0;
    cyc(1);
    mr_ni = 1'b1;
    cyc(D);
    check("R9 delay restarted by new cause", rst_no, 0);
    cyc(4);
    check("R9 release after restarted delay", rst_no, 1);
  endtask

  task automatic t_kick;
    int lows = 0;
    for (int i = 0; i < 4 * W; i++) begin
      cyc(1);
      if (!rst_no) lows++;
    end
    check("R5 both edges keep reset released", lows, 0);
  endtask

  task automatic t_timeout;
    int n = 0;
    int lo = 0;
    kick_en = 1'b0;
    cyc(1);
    wdi_i = ~wdi_i;
    while (rst_no && n < W + 20) begin
      cyc(1);
      n++;
    end
    check("R6 timeout clock count", n, W + 3);
    kick_en = 1'b1;
    while (!rst_no && lo < 100) begin
      lo++;
      cyc(1);
    end
    check("R6 hold after timeout", lo, D);
  endtask

  task automatic t_float;
    int lows = 0;
    kick_en = 1'b0;
    wdi_float_i = 1'b1;
    for (int i = 0; i < 5 * W; i++) begin
      cyc(1);
      if (!rst_no) lows++;
    end
    check("R7 floating input self-retriggers", lows, 0);
    wdi_float_i = 1'b0;
    kick_en = 1'b1;
    cyc(4);
  endtask

  task automatic t_wd_from_release;
    int n;
    kick_en = 1'b0;
    mr_ni = 1'b0;
    cyc(2 * W);
    mr_ni = 1'b1;
    cyc(D + 4);
    n = D + 4;
    check("R8 no timeout right at release", rst_no, 1);
    while (rst_no && n < D + W + 20) begin
      cyc(1);
      n++;
    end
    check_rng("R8 timeout counted from release", n, D + W + 1, D + W + 3);
    kick_en = 1'b1;
    cyc(D + 4);
  endtask

  task automatic t_tick;
    mr_ni = 1'b0;
    cyc(4);
    tick_i = 1'b0;
    mr_ni = 1'b1;
    cyc(40);
    check("R10 no progress without tick", rst_no, 0);
    tick_i = 1'b1;
    cyc(D - 1);
    check("R10 low one tick before expiry", rst_no, 0);
    cyc(2);
    check("R10 released after ticks resume", rst_no, 1);
  endtask

  initial begin
    t_power_on();
    t_rail_drop();
    t_manual();
    t_restart();
    t_kick();
    t_timeout();
    t_float();
    t_wd_from_release();
    t_tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule